// File: doc/BRIEF.md
# UART Two-Entry Receive Buffer

This block sits between a UART's receive shift register and the CPU-side read logic. Each time the deserializer completes a character, it presents the byte with its framing-error and parity-error status on a one-cycle strobe. The buffer stores up to two such bytes in arrival order, each with its own two error tags. It hands them to the reader oldest first.

The buffer reports its fill level and raises one-cycle events for a separate interrupt-flag block. One event marks a byte landing in an empty buffer, one marks a second byte joining an unread first byte, and one marks a byte lost because both entries were occupied. When the reader takes a byte that carried a framing or parity error, the buffer emits a clear pulse for that error flag. Once a byte is read, its data and tags are held on the read outputs until the next effective read.

A synchronous software-reset input empties the buffer. A read and a completed byte in the same cycle are resolved read-first, so a full buffer that is being drained does not overrun.

Top module: `uart_rxbuf`

## Requirements
- R1: After `rst_n` is low, `fill_lvl` is 0, `one_full`, `two_full`, all event and clear outputs are 0, and `rd_data`, `rd_frm_err` and `rd_par_err` are 0.
- R2: `fill_lvl` gives the number of stored bytes (0, 1 or 2). `one_full` is 1 whenever `fill_lvl` is not 0, and `two_full` is 1 exactly when `fill_lvl` is 2. `one_full` drops only when a read leaves the buffer empty.
- R3: When a byte is accepted into a buffer that is empty (after any read in the same cycle), `ev_load1` is high for exactly the one cycle following that clock edge.
- R4: When a byte is accepted while one unread byte remains (after any read in the same cycle), `ev_load2` is high for exactly the one cycle following that clock edge.
- R5: If `rx_done` arrives while two bytes remain after any same-cycle read, the byte is discarded, the stored bytes are unchanged, and `ev_ovr` is high for exactly the following cycle.
- R6: An `rd_stb` on a non-empty buffer removes the oldest byte. Its data appears on `rd_data` one cycle after the strobe edge and is held there until the next effective read.
- R7: Each entry keeps its own framing bit and parity bit. On a read, `rd_frm_err` and `rd_par_err` show the tags of the byte read. `clr_fe` (or `clr_pe`) pulses for one cycle, together with that data, when the byte read had a framing (or parity) error.
- R8: `rd_stb` and `rx_done` in the same cycle on a full buffer read the oldest byte and accept the new one. No overrun occurs, and `ev_load2` is raised.
- R9: `rd_stb` on an empty buffer changes nothing: `rd_data` and the tag outputs keep their values, no clear pulse is produced, and `fill_lvl` stays 0.
- R10: `sw_rst` high at a clock edge empties both entries and discards their error tags. This takes priority over `rx_done` and `rd_stb` in the same cycle, and raises no event. A later read on the emptied buffer produces no clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset, empties the buffer |
| rx_done | input | 1 | Strobe: a received byte is complete |
| rx_data | input | DATA_W | Received byte |
| rx_frm_err | input | 1 | Framing error status of the received byte |
| rx_par_err | input | 1 | Parity error status of the received byte |
| rd_stb | input | 1 | Strobe: the CPU reads the oldest byte |
| rd_data | output | DATA_W | Last byte read |
| rd_frm_err | output | 1 | Framing tag of the last byte read |
| rd_par_err | output | 1 | Parity tag of the last byte read |
| fill_lvl | output | 2 | Number of stored bytes |
| one_full | output | 1 | At least one byte stored |
| two_full | output | 1 | Both entries occupied |
| ev_load1 | output | 1 | Pulse: byte loaded into an empty buffer |
| ev_load2 | output | 1 | Pulse: second byte loaded |
| ev_ovr | output | 1 | Pulse: byte lost to overrun |
| clr_fe | output | 1 | Pulse: a framing-errored byte was read |
| clr_pe | output | 1 | Pulse: a parity-errored byte was read |

## Verification
Every result is registered once. The level outputs, the three load and overrun events, the read data, the tags and the clear pulses all change at the first rising edge that samples the strobe. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, half a period after the edge that produces the result. It then samples one cycle later again to confirm that each event and clear lasts exactly that one cycle. The same-cycle read and write cases, the empty read and the software reset are each held to the same one-edge timing.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;

   localparam int unsigned RXB_DEPTH = 2;

   typedef enum logic [1:0] {
      FILL_EMPTY = 2'd0,
      FILL_ONE   = 2'd1,
      FILL_TWO   = 2'd2
   } fill_e;

   // Fill level after an optional read; a read on an empty buffer is a no-op.
   function automatic fill_e fill_after_read(input fill_e cur, input logic rd);
      fill_e res;
      res = cur;
      if (rd) begin
         unique case (cur)
            FILL_TWO: res = FILL_ONE;
            FILL_ONE: res = FILL_EMPTY;
            default:  res = FILL_EMPTY;
         endcase
      end
      return res;
   endfunction

   function automatic fill_e fill_after_write(input fill_e cur);
      fill_e res;
      unique case (cur)
         FILL_EMPTY: res = FILL_ONE;
         default:    res = FILL_TWO;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
   import uart_rxbuf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sw_rst,
   input  logic  rx_done,
   input  logic  rd_stb,
   output fill_e fill_q,
   output logic  pop,
   output logic  wr_en,
   output logic  wr_slot,
   output logic  ev_load1_q,
   output logic  ev_load2_q,
   output logic  ev_ovr_q
);

   fill_e after_rd;
   fill_e fill_d;
   logic  ovr;

   always_comb begin
      pop      = rd_stb && (fill_q != FILL_EMPTY) && !sw_rst;
      after_rd = fill_after_read(fill_q, pop);
      wr_en    = rx_done && !sw_rst && (after_rd != FILL_TWO);
      ovr      = rx_done && !sw_rst && (after_rd == FILL_TWO);
      wr_slot  = (after_rd == FILL_ONE);
      if (sw_rst)     fill_d = FILL_EMPTY;
      else if (wr_en) fill_d = fill_after_write(after_rd);
      else            fill_d = after_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q     <= FILL_EMPTY;
         ev_load1_q <= 1'b0;
         ev_load2_q <= 1'b0;
         ev_ovr_q   <= 1'b0;
      end else begin
         fill_q     <= fill_d;
         ev_load1_q <= wr_en && (after_rd == FILL_EMPTY);
         ev_load2_q <= wr_en && (after_rd == FILL_ONE);
         ev_ovr_q   <= ovr;
      end
   end

endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
   import uart_rxbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned ENT_W = DATA_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_rst,
   input  logic             wr_en,
   input  logic             wr_slot,
   input  logic             pop,
   input  logic [ENT_W-1:0] wr_ent,
   output logic [ENT_W-1:0] head_ent
);

   logic [ENT_W-1:0] ent_q [RXB_DEPTH];

   // Entry 0 is always the oldest; a read shifts entry 1 down.
   for (genvar i = 0; i < RXB_DEPTH; i++) begin : g_ent
      logic [ENT_W-1:0] shift_in;
      logic             wr_here;

      if (i == RXB_DEPTH - 1) begin : g_tail
         assign shift_in = '0;
      end else begin : g_mid
         assign shift_in = ent_q[i+1];
      end

      assign wr_here = wr_en && (int'(wr_slot) == i);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ent_q[i] <= '0;
         else if (sw_rst)  ent_q[i] <= '0;
         else if (wr_here) ent_q[i] <= wr_ent;
         else if (pop)     ent_q[i] <= shift_in;
      end
   end

   assign head_ent = ent_q[0];

endmodule

// File: rtl/rxbuf_rdport.sv
module rxbuf_rdport #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned ENT_W = DATA_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              pop,
   input  logic [ENT_W-1:0]  head_ent,
   output logic [DATA_W-1:0] rd_data_q,
   output logic              rd_fe_q,
   output logic              rd_pe_q,
   output logic              clr_fe_q,
   output logic              clr_pe_q
);

   logic [DATA_W-1:0] head_data;
   logic              head_fe;
   logic              head_pe;

   assign {head_pe, head_fe, head_data} = head_ent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_q <= '0;
         rd_fe_q   <= 1'b0;
         rd_pe_q   <= 1'b0;
      end else if (pop) begin
         rd_data_q <= head_data;
         rd_fe_q   <= head_fe;
         rd_pe_q   <= head_pe;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_fe_q <= 1'b0;
         clr_pe_q <= 1'b0;
      end else begin
         clr_fe_q <= pop && head_fe && !sw_rst;
         clr_pe_q <= pop && head_pe && !sw_rst;
      end
   end

endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
   import uart_rxbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_frm_err,
   input  logic              rx_par_err,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_frm_err,
   output logic              rd_par_err,
   output logic [1:0]        fill_lvl,
   output logic              one_full,
   output logic              two_full,
   output logic              ev_load1,
   output logic              ev_load2,
   output logic              ev_ovr,
   output logic              clr_fe,
   output logic              clr_pe
);

   localparam int unsigned ENT_W = DATA_W + 2;

   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart_rxbuf: DATA_W must lie in 5..9");
   end

   fill_e            fill_q;
   logic             pop;
   logic             wr_en;
   logic             wr_slot;
   logic [ENT_W-1:0] head_ent;

   rxbuf_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_rst     (sw_rst),
      .rx_done    (rx_done),
      .rd_stb     (rd_stb),
      .fill_q     (fill_q),
      .pop        (pop),
      .wr_en      (wr_en),
      .wr_slot    (wr_slot),
      .ev_load1_q (ev_load1),
      .ev_load2_q (ev_load2),
      .ev_ovr_q   (ev_ovr)
   );

   rxbuf_store #(.DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_rst   (sw_rst),
      .wr_en    (wr_en),
      .wr_slot  (wr_slot),
      .pop      (pop),
      .wr_ent   ({rx_par_err, rx_frm_err, rx_data}),
      .head_ent (head_ent)
   );

   rxbuf_rdport #(.DATA_W(DATA_W)) u_rdport (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_rst    (sw_rst),
      .pop       (pop),
      .head_ent  (head_ent),
      .rd_data_q (rd_data),
      .rd_fe_q   (rd_frm_err),
      .rd_pe_q   (rd_par_err),
      .clr_fe_q  (clr_fe),
      .clr_pe_q  (clr_pe)
   );

   assign fill_lvl = fill_q;
   assign one_full = (fill_q != FILL_EMPTY);
   assign two_full = (fill_q == FILL_TWO);

endmodule

// File: rtl/uart_rxbuf_chk.sv
module uart_rxbuf_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_rst,
   input logic              rx_done,
   input logic              rd_stb,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_frm_err,
   input logic              rd_par_err,
   input logic [1:0]        fill_lvl,
   input logic              one_full,
   input logic              two_full,
   input logic              ev_load1,
   input logic              ev_load2,
   input logic              ev_ovr,
   input logic              clr_fe,
   input logic              clr_pe
);

   // R2
   fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_lvl != 2'd3);

   // R2
   one_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(one_full) |-> $past(rd_stb) || $past(sw_rst));

   // R3
   load1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_load1 |-> fill_lvl == 2'd1);

   // R4
   load2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_load2 |-> two_full);

   // R5
   ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ovr |-> two_full && $past(two_full) && $past(rx_done));

   // R3
   ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_load1, ev_load2, ev_ovr}));

   // R7
   clr_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_fe |-> rd_frm_err) and (clr_pe |-> rd_par_err));

   // R9
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && !one_full && !rx_done && !sw_rst |=>
         $stable(rd_data) && !clr_fe && !clr_pe && fill_lvl == 2'd0);

   // R10
   sw_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> fill_lvl == 2'd0 && !ev_load1 && !ev_load2 && !ev_ovr
                 && !clr_fe && !clr_pe);

endmodule

bind uart_rxbuf uart_rxbuf_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_rst     (sw_rst),
   .rx_done    (rx_done),
   .rd_stb     (rd_stb),
   .rd_data    (rd_data),
   .rd_frm_err (rd_frm_err),
   .rd_par_err (rd_par_err),
   .fill_lvl   (fill_lvl),
   .one_full   (one_full),
   .two_full   (two_full),
   .ev_load1   (ev_load1),
   .ev_load2   (ev_load2),
   .ev_ovr     (ev_ovr),
   .clr_fe     (clr_fe),
   .clr_pe     (clr_pe)
);

// File: tb/uart_rxbuf_test.sv
module uart_rxbuf_test;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_rst = 1'b0;
   logic          rx_done = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          rx_frm_err = 1'b0;
   logic          rx_par_err = 1'b0;
   logic          rd_stb = 1'b0;
   logic [DW-1:0] rd_data;
   logic          rd_frm_err, rd_par_err;
   logic [1:0]    fill_lvl;
   logic          one_full, two_full;
   logic          ev_load1, ev_load2, ev_ovr, clr_fe, clr_pe;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   uart_rxbuf #(.DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rx_done(rx_done),
      .rx_data(rx_data), .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err),
      .rd_stb(rd_stb), .rd_data(rd_data), .rd_frm_err(rd_frm_err),
      .rd_par_err(rd_par_err), .fill_lvl(fill_lvl), .one_full(one_full),
      .two_full(two_full), .ev_load1(ev_load1), .ev_load2(ev_load2),
      .ev_ovr(ev_ovr), .clr_fe(clr_fe), .clr_pe(clr_pe)
   );

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Events packed as {ev_load1, ev_load2, ev_ovr, clr_fe, clr_pe}.
   function automatic int evs();
      return int'({ev_load1, ev_load2, ev_ovr, clr_fe, clr_pe});
   endfunction

   // One-cycle strobes: drive at a falling edge, release at the next one.
   task automatic step(input logic wr, input logic [DW-1:0] d,
                       input logic fe, input logic pe, input logic rd,
                       input logic sr);
      rx_done = wr; rx_data = d; rx_frm_err = fe; rx_par_err = pe;
      rd_stb = rd; sw_rst = sr;
      @(negedge clk);
      rx_done = 1'b0; rd_stb = 1'b0; sw_rst = 1'b0;
      rx_frm_err = 1'b0; rx_par_err = 1'b0;
   endtask

   task automatic push(input logic [DW-1:0] d, input logic fe, input logic pe);
      step(1'b1, d, fe, pe, 1'b0, 1'b0);
   endtask

   task automatic pop();
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic idle_quiet(input string req);
      @(negedge clk);
      check(req, "events one cycle later", evs(), 0);
   endtask

   task automatic t_reset();
      check("R1", "fill", fill_lvl, 0);
      check("R1", "flags", {one_full, two_full}, 0);
      check("R1", "events", evs(), 0);
      check("R1", "rd outputs", {rd_frm_err, rd_par_err, rd_data}, 0);
   endtask

   task automatic t_single();
      push(8'hA5, 1'b0, 1'b0);
      check("R3", "load1 event", evs(), 5'b10000);
      check("R2", "fill one", {fill_lvl, one_full, two_full}, {2'd1, 2'b10});
      idle_quiet("R3");
      pop();
      check("R6", "rd_data", rd_data, 8'hA5);
      check("R2", "empty after read", {fill_lvl, one_full}, 0);
   endtask

   task automatic t_double();
      push(8'h11, 1'b0, 1'b0);
      push(8'h22, 1'b0, 1'b0);
      check("R4", "load2 event", evs(), 5'b01000);
      check("R2", "fill two", {fill_lvl, one_full, two_full}, {2'd2, 2'b11});
      idle_quiet("R4");
      pop();
      check("R6", "oldest first", rd_data, 8'h11);
      check("R2", "one_full held", {fill_lvl, one_full, two_full}, {2'd1, 2'b10});
      pop();
      check("R6", "second", rd_data, 8'h22);
      check("R2", "one_full drops", one_full, 0);
   endtask

   task automatic t_overrun();
      push(8'h31, 1'b0, 1'b0);
      push(8'h32, 1'b0, 1'b0);
      push(8'h33, 1'b1, 1'b1);
      check("R5", "ovr event", evs(), 5'b00100);
      check("R5", "fill stays", fill_lvl, 2);
      idle_quiet("R5");
      pop();
      check("R5", "first kept", rd_data, 8'h31);
      pop();
      check("R5", "second kept", {rd_frm_err, rd_par_err, rd_data}, 10'h032);
      check("R5", "third dropped", fill_lvl, 0);
   endtask

   task automatic t_errors();
      push(8'h41, 1'b1, 1'b0);
      push(8'h42, 1'b0, 1'b1);
      pop();
      check("R7", "clr_fe pulse", evs(), 5'b00010);
      check("R7", "tags byte1", {rd_frm_err, rd_par_err, rd_data}, {2'b10, 8'h41});
      idle_quiet("R7");
      pop();
      check("R7", "clr_pe pulse", evs(), 5'b00001);
      check("R7", "tags byte2", {rd_frm_err, rd_par_err, rd_data}, {2'b01, 8'h42});
   endtask

   task automatic t_full_rdwr();
      push(8'h51, 1'b0, 1'b0);
      push(8'h52, 1'b0, 1'b0);
      step(1'b1, 8'h53, 1'b0, 1'b0, 1'b1, 1'b0);
      check("R8", "no overrun, load2", evs(), 5'b01000);
      check("R8", "read data", rd_data, 8'h51);
      check("R8", "fill", fill_lvl, 2);
      pop();
      check("R8", "next", rd_data, 8'h52);
      pop();
      check("R8", "new byte kept", rd_data, 8'h53);
   endtask

   task automatic t_one_rdwr();
      push(8'h61, 1'b0, 1'b0);
      step(1'b1, 8'h62, 1'b0, 1'b0, 1'b1, 1'b0);
      check("R3", "load1 after same-cycle read", evs(), 5'b10000);
      check("R6", "read data", {fill_lvl, rd_data}, {2'd1, 8'h61});
      pop();
      check("R6", "new byte", {fill_lvl, rd_data}, {2'd0, 8'h62});
   endtask

   task automatic t_empty_read();
      push(8'h71, 1'b1, 1'b1);
      pop();
      pop();
      check("R9", "rd outputs kept", {rd_frm_err, rd_par_err, rd_data}, {2'b11, 8'h71});
      check("R9", "no clear, no event", evs(), 0);
      check("R9", "fill", fill_lvl, 0);
   endtask

   task automatic t_sw_rst();
      push(8'h81, 1'b1, 1'b1);
      push(8'h82, 1'b1, 1'b0);
      pop();
      step(1'b1, 8'h83, 1'b0, 1'b0, 1'b1, 1'b1);
      check("R10", "emptied", {fill_lvl, one_full, two_full}, 0);
      check("R10", "no events", evs(), 0);
      pop();
      check("R10", "read after reset no clear", evs(), 0);
      check("R10", "rd_data kept", rd_data, 8'h81);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_single();
      t_double();
      t_overrun();
      t_errors();
      t_full_rdwr();
      t_one_rdwr();
      t_empty_read();
      t_sw_rst();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule